// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer Counter

This block is a free-running up-counter with a selectable power-of-two clock divider in front of it, a load register, and a compare input. Each counting step either increments the counter or, when the counter sits at all ones, produces an overflow. On overflow the counter either reloads from the load register or falls back to zero. Two one-clock strobes report overflow and compare match to whatever logic sits around the timer.

Three write strobes change the count from outside. The first writes a value straight into the counter. The second writes the load register. The third forces an immediate reload from the load register. Each of these events, together with stopping the timer, treats the divider and the counter in its own way. A build-time parameter selects what happens when the counter overflows with reload off: it either keeps counting from zero, or it parks at zero until software intervenes.

Top module: `presc_reload_timer`

## Requirements
- R1: While `rst_n` is low, and for two rising clock edges after it rises, the counter, the load register, the divider and both strobes read zero.
- R2: While running with the divider off and no write pending, the counter advances by one on every clock.
- R3: With the divider on and ratio field `presc_sel` = k (3 bits), the counter advances once every 2^(k+1) clocks. If `presc_sel` is lowered below the divider's current position, the next running clock advances the counter.
- R4: When a counting step finds the counter at 0xFFFFFFFF, `ovf_pulse` is high for exactly the following clock. With `reload_en` set, the counter takes the load-register value, which gives a period of 2^32 − load counts.
- R5: With the default `ONE_SHOT`=0 and `reload_en` clear, an overflow sends the counter to zero, and counting carries on.
- R6: With `ONE_SHOT`=1 and `reload_en` clear, an overflow sends the counter to zero and holds it there. Counting resumes only after a direct write or a trigger write.
- R7: A `cnt_wr` pulse places `cnt_wdata` in the counter on the next clock and restarts the divider. It does this whether or not the timer runs, and it wins over a `trig_wr` in the same cycle.
- R8: A `trig_wr` pulse (without `cnt_wr`) places the load-register value held before that edge into the counter and restarts the divider.
- R9: An `ld_wr` pulse changes only the load register. The counter keeps its normal course in that cycle.
- R10: While `run_en` is low, the counter holds its value and the divider is cleared. After a restart, the first advance therefore takes a full divider period.
- R11: `match_pulse` is high for one clock after an increment brings the counter to `cmp_val` while `cmp_en` is set. There is no match when `cmp_en` is clear, or when the value arrives by a direct write or a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Counter runs while high |
| reload_en | input | 1 | Reload from load register on overflow |
| presc_en | input | 1 | Divider enable |
| presc_sel | input | PRE_W | Divider ratio, period 2^(sel+1) |
| cmp_en | input | 1 | Enables compare match |
| cmp_val | input | CNT_W | Compare value |
| cnt_wr | input | 1 | Direct counter write strobe |
| cnt_wdata | input | CNT_W | Direct counter write value |
| ld_wr | input | 1 | Load register write strobe |
| ld_wdata | input | CNT_W | Load register write value |
| trig_wr | input | 1 | Forced reload strobe |
| cnt_q | output | CNT_W | Current counter value |
| ovf_pulse | output | 1 | One-clock overflow strobe |
| match_pulse | output | 1 | One-clock compare match strobe |

## Verification
Several properties are checked on every clock. The assertions check the single-step increment, the frozen counter while stopped, the values that follow a direct write and a trigger write, the value after an overflow in each reload mode, the parked counter of the one-shot build, and the values that accompany a match strobe. Only the bench's scenarios can show the things that span many cycles. These are the length of each divider period, the shortened period after the ratio is lowered, and the full divider period after a stop. They also include the overflow-to-overflow spacing and the absence of a match after writes. A second instance built with `ONE_SHOT`=1 runs beside the default one.

// File: rtl/prt_pkg.sv
package prt_pkg;

  // Operation applied to the counter register on a clock edge
  typedef enum logic [2:0] {
    OP_HOLD   = 3'd0,
    OP_INC    = 3'd1,
    OP_SET    = 3'd2,
    OP_RELOAD = 3'd3,
    OP_WRAP   = 3'd4
  } cnt_op_e;

endpackage

// File: rtl/prt_rst_sync.sv
module prt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/prt_presc.sv
module prt_presc #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr,
  input  logic             run,
  input  logic             en,
  input  logic [PRE_W-1:0] sel,
  output logic             tick
);

  localparam int PC_W = 1 << PRE_W;

  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W:0]   span;
  logic [PC_W-1:0] lim;
  logic            hit;

  always_comb begin
    span = (PC_W+1)'(2) << sel;
    lim  = PC_W'(span - (PC_W+1)'(1));
    hit  = (pc_q >= lim);
    tick = run && !clr && (!en || hit);
    if (clr || !run || !en || hit) pc_d = '0;
    else                           pc_d = pc_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

endmodule

// File: rtl/prt_ctrl.sv
module prt_ctrl
  import prt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit ONE_SHOT = 1'b0
) (
  input  logic             cnt_wr,
  input  logic             trig_wr,
  input  logic             tick,
  input  logic             reload_en,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0] cnt_q,
  output cnt_op_e          op,
  output logic             ovf_evt,
  output logic             match_evt,
  output logic             halt_set
);

  logic [CNT_W-1:0] cnt_inc;
  logic             at_max;

  always_comb begin
    cnt_inc   = cnt_q + CNT_W'(1);
    at_max    = &cnt_q;
    op        = OP_HOLD;
    ovf_evt   = 1'b0;
    match_evt = 1'b0;
    halt_set  = 1'b0;
    if (cnt_wr) begin
      op = OP_SET;
    end else if (trig_wr) begin
      op = OP_RELOAD;
    end else if (tick) begin
      if (at_max) begin
        ovf_evt = 1'b1;
        if (reload_en) begin
          op = OP_RELOAD;
        end else begin
          op       = OP_WRAP;
          halt_set = ONE_SHOT;
        end
      end else begin
        op        = OP_INC;
        match_evt = cmp_en && (cnt_inc == cmp_val);
      end
    end
  end

endmodule

// File: rtl/prt_core.sv
module prt_core
  import prt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit ONE_SHOT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  cnt_op_e          op,
  input  logic [CNT_W-1:0] wdata,
  input  logic             ld_wr,
  input  logic [CNT_W-1:0] ld_wdata,
  input  logic             halt_set,
  input  logic             halt_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] ld_q,
  output logic             halted
);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = 1'b1;
    cnt_d  = cnt_q;
    unique case (op)
      OP_INC:    cnt_d = cnt_q + CNT_W'(1);
      OP_SET:    cnt_d = wdata;
      OP_RELOAD: cnt_d = ld_q;
      OP_WRAP:   cnt_d = '0;
      default:   cnt_ce = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    ld_q <= '0;
    else if (ld_wr) ld_q <= ld_wdata;
  end

  generate
    if (ONE_SHOT) begin : g_oneshot
      logic halt_q, halt_d;
      always_comb halt_d = halt_set || (halt_q && !halt_clr);
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) halt_q <= 1'b0;
        else         halt_q <= halt_d;
      end
      assign halted = halt_q;
    end else begin : g_freerun
      logic unused_halt;
      assign unused_halt = halt_set ^ halt_clr;
      assign halted      = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/presc_reload_timer.sv
module presc_reload_timer
  import prt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PRE_W    = 3,
  parameter bit ONE_SHOT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             reload_en,
  input  logic             presc_en,
  input  logic [PRE_W-1:0] presc_sel,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ld_wr,
  input  logic [CNT_W-1:0] ld_wdata,
  input  logic             trig_wr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_pulse,
  output logic             match_pulse
);

  logic             rst_int_n;
  logic             tick;
  logic             halted;
  logic             wr_any;
  logic             ovf_evt, match_evt, halt_set;
  logic [CNT_W-1:0] ld_q;
  cnt_op_e          op;

  assign wr_any = cnt_wr || trig_wr;

  prt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  prt_presc #(.PRE_W(PRE_W)) u_presc (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .clr    (wr_any),
    .run    (run_en && !halted),
    .en     (presc_en),
    .sel    (presc_sel),
    .tick   (tick)
  );

  prt_ctrl #(.CNT_W(CNT_W), .ONE_SHOT(ONE_SHOT)) u_ctrl (
    .cnt_wr    (cnt_wr),
    .trig_wr   (trig_wr),
    .tick      (tick),
    .reload_en (reload_en),
    .cmp_en    (cmp_en),
    .cmp_val   (cmp_val),
    .cnt_q     (cnt_q),
    .op        (op),
    .ovf_evt   (ovf_evt),
    .match_evt (match_evt),
    .halt_set  (halt_set)
  );

  prt_core #(.CNT_W(CNT_W), .ONE_SHOT(ONE_SHOT)) u_core (
    .clk      (clk),
    .rst_ni   (rst_int_n),
    .op       (op),
    .wdata    (cnt_wdata),
    .ld_wr    (ld_wr),
    .ld_wdata (ld_wdata),
    .halt_set (halt_set),
    .halt_clr (wr_any),
    .cnt_q    (cnt_q),
    .ld_q     (ld_q),
    .halted   (halted)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ovf_pulse   <= 1'b0;
      match_pulse <= 1'b0;
    end else begin
      ovf_pulse   <= ovf_evt;
      match_pulse <= match_evt;
    end
  end

endmodule

// File: rtl/prt_checker.sv
module prt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             run_en,
  input logic             reload_en,
  input logic             presc_en,
  input logic             cmp_en,
  input logic [CNT_W-1:0] cmp_val,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             trig_wr,
  input logic [CNT_W-1:0] ld_q,
  input logic             halted,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_pulse,
  input logic             match_pulse
);

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_en && !presc_en && !cnt_wr && !trig_wr && !halted && !(&cnt_q))
      |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_ovf_from_max_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf_pulse |-> &($past(cnt_q)));

  p_ovf_reload_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (ovf_pulse && $past(reload_en)) |-> cnt_q == $past(ld_q));

  p_ovf_single_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf_pulse |=> !ovf_pulse);

  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (ovf_pulse && !$past(reload_en)) |-> cnt_q == '0);

  p_oneshot_park_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (halted && !cnt_wr && !trig_wr) |=> (cnt_q == '0) && !ovf_pulse);

  p_direct_write_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_wr |=> cnt_q == $past(cnt_wdata));

  p_trigger_reload_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (trig_wr && !cnt_wr) |=> cnt_q == $past(ld_q));

  p_stop_freeze_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run_en && !cnt_wr && !trig_wr) |=> $stable(cnt_q) && !ovf_pulse && !match_pulse);

  p_match_value_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    match_pulse |-> (cnt_q == $past(cmp_val)) && $past(cmp_en));

endmodule

bind presc_reload_timer prt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_ni      (rst_int_n),
  .run_en      (run_en),
  .reload_en   (reload_en),
  .presc_en    (presc_en),
  .cmp_en      (cmp_en),
  .cmp_val     (cmp_val),
  .cnt_wr      (cnt_wr),
  .cnt_wdata   (cnt_wdata),
  .trig_wr     (trig_wr),
  .ld_q        (ld_q),
  .halted      (halted),
  .cnt_q       (cnt_q),
  .ovf_pulse   (ovf_pulse),
  .match_pulse (match_pulse)
);

// File: tb/presc_reload_timer_bench.sv
`timescale 1ns/1ps
module presc_reload_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_en, reload_en, presc_en, cmp_en, cnt_wr, ld_wr, trig_wr;
  logic [2:0]  presc_sel;
  logic [31:0] cmp_val, cnt_wdata, ld_wdata;
  logic [31:0] cnt_a, cnt_b;
  logic        ovf_a, ovf_b, mt_a, mt_b;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc_cnt = 0;
  bit done    = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  presc_reload_timer u_presc_reload_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .reload_en(reload_en),
    .presc_en(presc_en), .presc_sel(presc_sel), .cmp_en(cmp_en), .cmp_val(cmp_val),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ld_wr(ld_wr), .ld_wdata(ld_wdata),
    .trig_wr(trig_wr), .cnt_q(cnt_a), .ovf_pulse(ovf_a), .match_pulse(mt_a)
  );

  presc_reload_timer #(.ONE_SHOT(1'b1)) u_presc_reload_timer_os (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .reload_en(reload_en),
    .presc_en(presc_en), .presc_sel(presc_sel), .cmp_en(cmp_en), .cmp_val(cmp_val),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ld_wr(ld_wr), .ld_wdata(ld_wdata),
    .trig_wr(trig_wr), .cnt_q(cnt_b), .ovf_pulse(ovf_b), .match_pulse(mt_b)
  );

  // Behavioural reference: index 0 free-running build, index 1 one-shot build
  logic [31:0] m_cnt [2];
  logic [31:0] m_ld  [2];
  int          m_pc  [2];
  bit          m_halt[2];
  bit          m_ovf [2];
  bit          m_mt  [2];
  bit          rs1, rs2;

  always @(posedge clk or negedge rst_n) begin
    bit live;
    if (!rst_n) begin
      rs1 = 1'b0; rs2 = 1'b0; live = 1'b0;
    end else begin
      live = rs2; rs2 = rs1; rs1 = 1'b1;
    end
    for (int k = 0; k < 2; k++) begin
      if (!live) begin
        m_cnt[k] = 0; m_ld[k] = 0; m_pc[k] = 0; m_halt[k] = 0; m_ovf[k] = 0; m_mt[k] = 0;
      end else begin
        m_ovf[k] = 0; m_mt[k] = 0;
        if (cnt_wr) begin
          m_cnt[k] = cnt_wdata; m_pc[k] = 0; m_halt[k] = 0;
        end else if (trig_wr) begin
          m_cnt[k] = m_ld[k]; m_pc[k] = 0; m_halt[k] = 0;
        end else if (!run_en || m_halt[k]) begin
          m_pc[k] = 0;
        end else begin
          int lim;
          bit tk;
          lim = (2 << presc_sel) - 1;
          tk  = !presc_en || (m_pc[k] >= lim);
          m_pc[k] = (presc_en && !tk) ? m_pc[k] + 1 : 0;
          if (tk) begin
            if (m_cnt[k] == 32'hFFFF_FFFF) begin
              m_ovf[k] = 1;
              if (reload_en) m_cnt[k] = m_ld[k];
              else begin
                m_cnt[k] = 0;
                if (k == 1) m_halt[k] = 1;
              end
            end else begin
              m_cnt[k] = m_cnt[k] + 1;
              m_mt[k]  = cmp_en && (m_cnt[k] == cmp_val);
            end
          end
        end
        if (ld_wr) m_ld[k] = ld_wdata;
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Every-cycle comparison against the reference, mid high phase
  always @(posedge clk) begin
    #5;
    if (!done) begin
      chk(cur_req, "cnt", cnt_a, m_cnt[0]);
      chk(cur_req, "ovf", {31'b0, ovf_a}, {31'b0, m_ovf[0]});
      chk(cur_req, "match", {31'b0, mt_a}, {31'b0, m_mt[0]});
      chk(cur_req, "os cnt", cnt_b, m_cnt[1]);
      chk(cur_req, "os ovf", {31'b0, ovf_b}, {31'b0, m_ovf[1]});
      chk(cur_req, "os match", {31'b0, mt_b}, {31'b0, m_mt[1]});
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL %s watchdog: actual %0d cycles expected below 100000", cur_req, cyc_cnt);
      finish_run();
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cnt(logic [31:0] v);
    cnt_wr = 1'b1; cnt_wdata = v; cyc(1); cnt_wr = 1'b0;
  endtask

  task automatic wr_ld(logic [31:0] v);
    ld_wr = 1'b1; ld_wdata = v; cyc(1); ld_wr = 1'b0;
  endtask

  task automatic pulse_trig();
    trig_wr = 1'b1; cyc(1); trig_wr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; run_en = 0; reload_en = 0; presc_en = 0; presc_sel = 0;
    cmp_en = 0; cmp_val = 0; cnt_wr = 0; cnt_wdata = 0; ld_wr = 0; ld_wdata = 0; trig_wr = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    chk("R1", "cnt after reset", cnt_a, 32'd0);
    chk("R1", "strobes after reset", {30'b0, ovf_a, mt_a}, 32'd0);

    cur_req = "R2";
    run_en = 1'b1;
    cyc(10);
    chk("R2", "cnt after 10 clocks", cnt_a, 32'd10);

    cur_req = "R9";
    wr_ld(32'hFFFF_FFF0);
    chk("R9", "cnt unaffected by load write", cnt_a, 32'd11);

    cur_req = "R8";
    pulse_trig();
    chk("R8", "cnt after trigger", cnt_a, 32'hFFFF_FFF0);
    cyc(15);
    chk("R8", "cnt before overflow", cnt_a, 32'hFFFF_FFFF);

    cur_req = "R5";
    cyc(1);
    chk("R5", "wrap to zero", cnt_a, 32'd0);
    chk("R5", "ovf strobe", {31'b0, ovf_a}, 32'd1);
    cur_req = "R6";
    cyc(3);
    chk("R5", "keeps counting", cnt_a, 32'd3);
    chk("R6", "one-shot parked", cnt_b, 32'd0);
    chk("R4", "strobe one clock", {31'b0, ovf_a}, 32'd0);

    cur_req = "R7";
    cnt_wr = 1'b1; trig_wr = 1'b1; cnt_wdata = 32'hFFFF_FFFD;
    cyc(1);
    cnt_wr = 1'b0; trig_wr = 1'b0;
    chk("R7", "direct write wins", cnt_a, 32'hFFFF_FFFD);
    chk("R7", "one-shot released", cnt_b, 32'hFFFF_FFFD);

    cur_req = "R4";
    reload_en = 1'b1;
    wr_ld(32'hFFFF_FFF8);
    cyc(2);
    chk("R4", "reload value", cnt_a, 32'hFFFF_FFF8);
    chk("R4", "ovf strobe", {31'b0, ovf_a}, 32'd1);
    cyc(8);
    chk("R4", "period of 8", cnt_a, 32'hFFFF_FFF8);
    chk("R4", "ovf strobe again", {31'b0, ovf_a}, 32'd1);

    cur_req = "R11";
    cmp_en = 1'b1; cmp_val = 32'hFFFF_FFFB;
    cyc(3);
    chk("R11", "match strobe", {31'b0, mt_a}, 32'd1);
    cyc(1);
    chk("R11", "match one clock", {31'b0, mt_a}, 32'd0);
    cmp_en = 1'b0;
    cyc(7);
    chk("R11", "no match when disabled", {31'b0, mt_a}, 32'd0);
    cmp_en = 1'b1;
    wr_cnt(32'hFFFF_FFFB);
    chk("R11", "no match on write", {31'b0, mt_a}, 32'd0);

    cur_req = "R3";
    reload_en = 1'b0; cmp_en = 1'b0;
    wr_cnt(32'd100);
    presc_en = 1'b1; presc_sel = 3'd1;
    cyc(3);
    chk("R3", "no advance before 4 clocks", cnt_a, 32'd100);
    cyc(1);
    chk("R3", "advance at 4 clocks", cnt_a, 32'd101);
    cyc(8);
    chk("R3", "ratio 1", cnt_a, 32'd103);
    presc_sel = 3'd0;
    cyc(4);
    chk("R3", "ratio 0", cnt_a, 32'd105);
    presc_sel = 3'd7;
    cyc(256);
    chk("R3", "ratio 7", cnt_a, 32'd106);
    cyc(100);
    chk("R3", "ratio 7 mid period", cnt_a, 32'd106);
    presc_sel = 3'd2;
    cyc(1);
    chk("R3", "lowered ratio advances", cnt_a, 32'd107);

    cur_req = "R10";
    cyc(5);
    run_en = 1'b0;
    cyc(4);
    chk("R10", "frozen while stopped", cnt_a, 32'd107);
    run_en = 1'b1;
    cyc(7);
    chk("R10", "full period after restart", cnt_a, 32'd107);
    cyc(1);
    chk("R10", "advance after restart", cnt_a, 32'd108);

    cur_req = "R7";
    cyc(3);
    wr_cnt(32'd500);
    cyc(7);
    chk("R7", "divider restarted", cnt_a, 32'd500);
    cyc(1);
    chk("R7", "advance after write", cnt_a, 32'd501);
    run_en = 1'b0;
    wr_cnt(32'd7);
    chk("R7", "write while stopped", cnt_a, 32'd7);
    cyc(2);

    finish_run();
  end

endmodule